// File: doc/BRIEF.md
# Slip-Assist Current Step Controller

This block drives a bank of extra constant-current charge-pump cells that widen the linear range of a phase detector during frequency acquisition. When the phase-error logic flags that a cycle slip is about to happen, the controller switches on one more cell. Cells are added one at a time, up to a fixed ceiling. A direction request picks whether the extra current is sourced into the loop filter or sunk from it, and that choice is captured when the first cell turns on. Once the VCO is reported to have gone past the target frequency, the controller switches the cells back off one at a time until none are left. It then waits for the next acquisition.

The block makes all of its decisions on cycles where the comparison-clock strobe is high. It acts only while it is enabled and the detector polarity is positive. If either condition goes away, every cell turns off at once and the sequence starts again from empty. The cell enables are thermometer coded, so the analog bank only ever sees a contiguous run of active cells starting at cell 0.

Top module: `slipguard_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all cell enables and the source/sink sign read 0.
- R2: When idle and active (enable high, polarity positive), a strobe cycle with slip_soon high turns on exactly one cell and captures dir_up into src_up (1 = source, 0 = sink). The result is visible after that clock edge.
- R3: The cell enables are thermometer coded: cell_en[k] is 1 exactly when the active cell count is greater than k.
- R4: While ramping up, each strobe cycle with slip_soon high and past_target low adds one cell. Once NCELLS cells are on, further slip_soon strobes leave the count unchanged.
- R5: While ramping up, a strobe cycle with past_target high starts the ramp-down and leaves the count unchanged at that strobe. past_target takes priority over slip_soon.
- R6: While ramping down, each strobe cycle removes one cell and slip_soon is ignored. When the count reaches 0 the block returns to idle and src_up reads 0.
- R7: While any cell is on, src_up keeps its captured value regardless of dir_up.
- R8: Count, sign and state change only on cycles where strobe is high, or when the block becomes inactive.
- R9: When enable is low or pol_pos is low, all cell enables and src_up read 0 in that same cycle. The count and state are cleared, so after reactivation the block is idle with no cells on.
- R10: past_target seen while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Function enable |
| pol_pos | input | 1 | Phase detector polarity is positive |
| strobe | input | 1 | One-cycle comparison-clock tick that qualifies all decisions |
| slip_soon | input | 1 | Cycle slip is imminent |
| past_target | input | 1 | VCO has passed the target frequency |
| dir_up | input | 1 | Tuning voltage must rise (1 = source current) |
| cell_en | output | NCELLS | Thermometer enables for the extra cells |
| src_up | output | 1 | 1 = extra cells source current, 0 = sink |

## Verification
The bench builds the controller with the default of seven cells and a three-bit count. With these values, reaching the ceiling and saturating take only a handful of strobes, so the bench drives past the full bank and then ramps all the way back down within one short sequence. The same build reaches a ramp-down that starts from a single cell, and removal of the enable or the polarity in the middle of a ramp, in both the sourcing and the sinking direction.

// File: rtl/slipguard_pkg.sv
// Shared types for the slip-assist current step controller.
// Assumes: three sequencer phases are enough; encoding carries no meaning.
package slipguard_pkg;

    typedef enum logic [1:0] {
        SG_IDLE      = 2'd0,
        SG_RAMP_UP   = 2'd1,
        SG_RAMP_DOWN = 2'd2
    } sg_state_e;

endpackage

// File: rtl/slipguard_seq.sv
// Sequencer: holds the active cell count, the captured current sign and the
// ramp phase. All decisions are qualified by the strobe. Leaving the active
// condition clears everything on the next edge.
// Assumes: strobe is a single-cycle tick; slip/target flags are synchronous.
module slipguard_seq
    import slipguard_pkg::*;
#(
    parameter int NCELLS = 7,
    parameter int CNT_W  = $clog2(NCELLS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             strobe,
    input  logic             slip_soon,
    input  logic             past_target,
    input  logic             dir_up,
    output logic [CNT_W-1:0] count,
    output logic             sign_q,
    output sg_state_e        state
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NCELLS);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] count_n;
    logic             sign_n;
    sg_state_e        state_n;

    // Next-state decision for count, sign and phase.
    always_comb begin
        count_n = count;
        sign_n  = sign_q;
        state_n = state;
        if (!active) begin
            count_n = '0;
            sign_n  = 1'b0;
            state_n = SG_IDLE;
        end else if (strobe) begin
            unique case (state)
                SG_IDLE: begin
                    if (slip_soon) begin
                        count_n = CNT_ONE;
                        sign_n  = dir_up;
                        state_n = SG_RAMP_UP;
                    end
                end
                SG_RAMP_UP: begin
                    if (past_target) begin
                        state_n = SG_RAMP_DOWN;
                    end else if (slip_soon && (count < CNT_MAX)) begin
                        count_n = count + CNT_ONE;
                    end
                end
                SG_RAMP_DOWN: begin
                    count_n = count - CNT_ONE;
                    if (count == CNT_ONE) begin
                        sign_n  = 1'b0;
                        state_n = SG_IDLE;
                    end
                end
                default: begin
                    count_n = '0;
                    sign_n  = 1'b0;
                    state_n = SG_IDLE;
                end
            endcase
        end
    end

    // Register the sequencer state with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count  <= '0;
            sign_q <= 1'b0;
            state  <= SG_IDLE;
        end else begin
            count  <= count_n;
            sign_q <= sign_n;
            state  <= state_n;
        end
    end

endmodule

// File: rtl/slipguard_therm.sv
// Thermometer decoder: cell k is on when the count exceeds k and the
// controller is active.
// Assumes: count never exceeds NCELLS.
module slipguard_therm #(
    parameter int NCELLS = 7,
    parameter int CNT_W  = $clog2(NCELLS + 1)
) (
    input  logic [CNT_W-1:0]  count,
    input  logic              active,
    output logic [NCELLS-1:0] cell_en
);

    // One comparator per cell.
    for (genvar k = 0; k < NCELLS; k++) begin : g_cell
        assign cell_en[k] = active && (count > CNT_W'(k));
    end

endmodule

// File: rtl/slipguard_ctrl.sv
// Top of the slip-assist current step controller. It gates the function on
// enable and positive polarity, runs the sequencer, and decodes the count
// into thermometer cell enables plus a source/sink sign.
// Assumes: all inputs are synchronous to clk.
module slipguard_ctrl
    import slipguard_pkg::*;
#(
    parameter int NCELLS = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pol_pos,
    input  logic              strobe,
    input  logic              slip_soon,
    input  logic              past_target,
    input  logic              dir_up,
    output logic [NCELLS-1:0] cell_en,
    output logic              src_up
);

    localparam int CNT_W = $clog2(NCELLS + 1);

    logic             active;
    logic [CNT_W-1:0] count;
    logic             sign_q;
    sg_state_e        state;

    // Function runs only when enabled with positive detector polarity.
    assign active = enable && pol_pos;
    assign src_up = active && sign_q;

    slipguard_seq #(.NCELLS(NCELLS), .CNT_W(CNT_W)) seq_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (active),
        .strobe      (strobe),
        .slip_soon   (slip_soon),
        .past_target (past_target),
        .dir_up      (dir_up),
        .count       (count),
        .sign_q      (sign_q),
        .state       (state)
    );

    slipguard_therm #(.NCELLS(NCELLS), .CNT_W(CNT_W)) therm_i (
        .count   (count),
        .active  (active),
        .cell_en (cell_en)
    );

endmodule

// File: rtl/slipguard_chk.sv
// Checker for slipguard_ctrl: port-level properties over time.
module slipguard_chk #(
    parameter int NCELLS = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable,
    input logic              pol_pos,
    input logic              strobe,
    input logic [NCELLS-1:0] cell_en,
    input logic              src_up
);

    localparam logic [NCELLS-1:0] ONE = NCELLS'(1);

    logic              act;
    logic [NCELLS-1:0] plus1;
    assign act   = enable && pol_pos;
    assign plus1 = cell_en + ONE;

    AST_THERMO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (cell_en & plus1) == '0); // R3

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        act |=> (!act || (($countones(cell_en) <= $countones($past(cell_en)) + 1) &&
                          ($countones($past(cell_en)) <= $countones(cell_en) + 1)))); // R4

    AST_FIRST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cell_en == '0) |=> (!act || $countones(cell_en) <= 1)); // R2

    AST_INACTIVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !act |=> (cell_en == '0 && !src_up)); // R9

    AST_STROBE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (act && !strobe) |=> (!act || ($stable(cell_en) && $stable(src_up)))); // R8

    AST_SIGN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (act && cell_en != '0) |=> (!act || cell_en == '0 || $stable(src_up))); // R7

endmodule

bind slipguard_ctrl slipguard_chk #(.NCELLS(NCELLS)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable),
    .pol_pos (pol_pos),
    .strobe  (strobe),
    .cell_en (cell_en),
    .src_up  (src_up)
);

// File: tb/slipguard_ctrl_tb.sv
`timescale 1ns/1ps
module slipguard_ctrl_tb_top;

    localparam int N = 7;

    typedef struct {
        logic [N-1:0] cells;
        logic         src;
        string        tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, pol_pos = 1'b0, strobe = 1'b0;
    logic slip_soon = 1'b0, past_target = 1'b0, dir_up = 1'b0;
    logic [N-1:0] cell_en;
    logic src_up;

    int checks = 0;
    int errors = 0;
    exp_t sb_q[$];

    // model state, derived from the requirements
    int m_cnt = 0;
    int m_ph  = 0; // 0 idle, 1 up, 2 down
    logic m_sgn = 1'b0;

    always #2.5 clk = ~clk;

    slipguard_ctrl #(.NCELLS(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable), .pol_pos(pol_pos),
        .strobe(strobe), .slip_soon(slip_soon), .past_target(past_target),
        .dir_up(dir_up), .cell_en(cell_en), .src_up(src_up)
    );

    function automatic logic [N-1:0] therm(int c);
        logic [N-1:0] v = '0;
        for (int k = 0; k < N; k++) v[k] = (c > k);
        return v;
    endfunction

    // Driver: one clock of stimulus, model update, expectation pushed.
    task automatic cyc(input logic en, input logic pol, input logic stb,
                       input logic slp, input logic ov, input logic dir,
                       input string tag);
        exp_t e;
        logic act;
        @(negedge clk);
        enable = en; pol_pos = pol; strobe = stb;
        slip_soon = slp; past_target = ov; dir_up = dir;
        act = en && pol;
        if (!act) begin
            m_cnt = 0; m_ph = 0; m_sgn = 1'b0;
        end else if (stb) begin
            if (m_ph == 0) begin
                if (slp) begin m_cnt = 1; m_sgn = dir; m_ph = 1; end
            end else if (m_ph == 1) begin
                if (ov) m_ph = 2;
                else if (slp && m_cnt < N) m_cnt++;
            end else begin
                m_cnt--;
                if (m_cnt == 0) begin m_ph = 0; m_sgn = 1'b0; end
            end
        end
        e.cells = act ? therm(m_cnt) : '0;
        e.src   = act ? m_sgn : 1'b0;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    // Monitor: pops the expectation and compares just after the edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (cell_en !== e.cells) begin
                errors++;
                $display("FAIL %s cell_en actual=%b expected=%b", e.tag, cell_en, e.cells);
            end
            checks++;
            if (src_up !== e.src) begin
                errors++;
                $display("FAIL %s src_up actual=%b expected=%b", e.tag, src_up, e.src);
            end
        end
    end

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        cyc(1, 1, 0, 0, 0, 0, "R1 reset state");
        cyc(1, 1, 1, 0, 1, 0, "R10 target in idle");
        cyc(1, 1, 0, 1, 0, 1, "R8 slip without strobe");
        cyc(1, 1, 1, 1, 0, 1, "R2 first cell source");
        cyc(1, 1, 1, 1, 0, 0, "R7 dir change ignored");
        cyc(1, 1, 0, 1, 0, 0, "R8 hold between strobes");
        for (int i = 0; i < 7; i++) cyc(1, 1, 1, 1, 0, 1, "R4 ramp up and saturate");
        cyc(1, 1, 1, 1, 1, 0, "R5 target over slip");
        cyc(1, 1, 1, 1, 0, 0, "R6 slip ignored in ramp down");
        cyc(1, 1, 0, 0, 0, 0, "R8 no strobe in ramp down");
        for (int i = 0; i < 6; i++) cyc(1, 1, 1, 0, 0, 0, "R6 ramp down to zero");
        cyc(1, 1, 1, 0, 0, 0, "R6 idle after ramp down");
        cyc(1, 1, 1, 1, 0, 0, "R2 first cell sink");
        cyc(1, 1, 1, 1, 0, 1, "R3 two cells");
        cyc(1, 1, 1, 1, 0, 1, "R3 three cells");
        cyc(1, 0, 0, 0, 0, 1, "R9 negative polarity");
        cyc(1, 1, 0, 0, 0, 1, "R9 cleared after reactivation");
        cyc(1, 1, 1, 1, 0, 1, "R2 restart source");
        cyc(0, 1, 0, 0, 0, 1, "R9 enable low");
        cyc(1, 1, 1, 0, 1, 1, "R10 target after reenable");
        cyc(1, 1, 1, 1, 0, 0, "R2 single cell");
        cyc(1, 1, 1, 0, 1, 0, "R5 ramp down from one");
        cyc(1, 1, 1, 0, 0, 0, "R6 one to zero");
        cyc(1, 1, 1, 1, 0, 1, "R6 new acquisition from idle");
        @(negedge clk);
        @(negedge clk);
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule